// File: doc/BRIEF.md
# Direct-Mapped Data Cache with Victim Buffer

This block is a small data cache for one load/store client. The main store is direct-mapped, one line per index. Beside it sits a small fully associative buffer. That buffer keeps the lines that misses have pushed out of the main store. When a request misses the main store, the buffer is searched first. A line found there is swapped back into the main store. In the same operation, the line it displaces takes the freed buffer slot. Only when both structures miss does the block ask the next memory level for the whole line.

The client side uses a valid/ready handshake. Each accepted request produces exactly one single-cycle response pulse. The memory side is line-granular. A request pulse carries a line address and, for a write, the whole line. A read is answered later by a single-cycle response pulse that carries the line. Only one miss is in flight at a time, and no new request is accepted until the current one has been answered.

Top module: `vcache_top`

## Requirements
- R1: After reset, `req_ready` is 1, `resp_valid` is 0 and `mem_req_valid` is 0, and every line is invalid, so the first access to any address goes to memory.
- R2: A load that hits the main store returns its word on `resp_rdata` with `resp_valid` high in the cycle after acceptance. A store hit responds with the same timing, echoes the stored word and writes it into the line. Neither makes any memory request.
- R3: `req_addr` is a word address. Line address = `req_addr[ADDR_W-1:2]` (4 words per line) and word offset = `req_addr[1:0]`. Index = the low log2(SETS) bits of the line address. Two lines with the same index never reside in the main store together.
- R4: A request that misses both structures issues exactly one memory read (`mem_req_we`=0) for its line address. It then returns the requested word, and for a store merges the stored word. The line is then resident, so a further access to it hits.
- R5: On a main-store miss the buffer is probed before any memory request. A buffer hit issues no memory request at all.
- R6: A buffer hit responds three cycles after acceptance (one plus a two-cycle swap). The requested line goes to the main store and the displaced line goes into the freed slot. Two conflicting lines can therefore alternate with no memory traffic.
- R7: A line enters the buffer only when a miss displaces it from the main store. Lines brought in by refills do not take buffer slots. Buffer entries are matched on the full line address.
- R8: The buffer holds VB_ENTRIES lines (1 to 8, default 8). When a new line must enter a full buffer, the entry inserted least recently is overwritten. A swap counts as an insertion into the freed slot.
- R9: Dirty lines stay dirty in the buffer. A dirty line about to be overwritten is first written to memory (`mem_req_we`=1, its own line address, its current data). That write comes before the read request for the miss that caused it.
- R10: A clean line that is overwritten in the buffer produces no memory write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Client request present |
| req_ready | output | 1 | Block can accept a request this cycle |
| req_we | input | 1 | 1 = store, 0 = load |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Store data |
| resp_valid | output | 1 | One-cycle response pulse |
| resp_rdata | output | DATA_W | Loaded word, or the stored word for a store |
| mem_req_valid | output | 1 | One-cycle memory request pulse |
| mem_req_we | output | 1 | 1 = line write-back, 0 = line read |
| mem_req_line | output | ADDR_W-2 | Line address of the request |
| mem_req_wdata | output | 4*DATA_W | Line data for a write-back |
| mem_resp_valid | input | 1 | Read data returned |
| mem_resp_rdata | input | 4*DATA_W | Returned line |

## Verification
Broken buffer bookkeeping shows up at the ports as a change in latency or traffic. A lost victim turns a three-cycle response into a memory read. A stale or misordered age picks the wrong line to push out, and the memory write or read then carries an unexpected line address. Both appear on the very access that depends on the damaged entry. A dropped dirty bit is seen later, as wrong data when the pushed-out line is fetched again. The directed sequences therefore drive nine conflicting evictions into one index, then re-read the pushed-out line and one survivor.

// File: rtl/vcache_pkg.sv
package vcache_pkg;

  // Control sequence of the cache; the order is the order of traversal
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SWAP_A,
    ST_SWAP_B,
    ST_EVICT_WR,
    ST_FETCH_RQ,
    ST_FETCH_WT
  } vc_state_e;

endpackage

// File: rtl/vc_main_array.sv
module vc_main_array #(
  parameter int SETS   = 16,
  parameter int TAG_W  = 6,
  parameter int LINE_W = 128,
  localparam int IDX_W = $clog2(SETS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic              rd_valid,
  output logic              rd_dirty,
  output logic [TAG_W-1:0]  rd_tag,
  output logic [LINE_W-1:0] rd_line,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic              wr_dirty,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [LINE_W-1:0] wr_line
);

  logic [SETS-1:0]   vld_q;
  logic [SETS-1:0]   drt_q;
  logic [TAG_W-1:0]  tag_q  [SETS];
  logic [LINE_W-1:0] line_q [SETS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= '0;
      drt_q <= '0;
    end else if (wr_en) begin
      vld_q[wr_idx] <= 1'b1;
      drt_q[wr_idx] <= wr_dirty;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q[wr_idx]  <= wr_tag;
      line_q[wr_idx] <= wr_line;
    end
  end

  assign rd_valid = vld_q[rd_idx];
  assign rd_dirty = drt_q[rd_idx];
  assign rd_tag   = tag_q[rd_idx];
  assign rd_line  = line_q[rd_idx];

endmodule

// File: rtl/vc_victim_buf.sv
module vc_victim_buf #(
  parameter int ENTRIES = 8,
  parameter int LA_W    = 10,
  parameter int LINE_W  = 128,
  localparam int SLOT_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  // associative probe
  input  logic [LA_W-1:0]   probe_la,
  output logic              hit,
  output logic [SLOT_W-1:0] hit_slot,
  output logic              hit_dirty,
  output logic [LINE_W-1:0] hit_line,
  // slot that the next insertion would take
  output logic [SLOT_W-1:0] repl_slot,
  output logic              repl_valid,
  output logic              repl_dirty,
  output logic [LA_W-1:0]   repl_la,
  output logic [LINE_W-1:0] repl_line,
  // slot update: insert (upd_valid=1) or free (upd_valid=0)
  input  logic              upd_en,
  input  logic [SLOT_W-1:0] upd_slot,
  input  logic              upd_valid,
  input  logic              upd_dirty,
  input  logic [LA_W-1:0]   upd_la,
  input  logic [LINE_W-1:0] upd_line
);

  logic [ENTRIES-1:0] vld_q;
  logic [ENTRIES-1:0] drt_q;
  logic [LA_W-1:0]    la_q   [ENTRIES];
  logic [LINE_W-1:0]  line_q [ENTRIES];
  logic [SLOT_W-1:0]  age_q  [ENTRIES];

  logic [ENTRIES-1:0] hit_vec;
  logic [ENTRIES-1:0] oldest_vec;

  // Per-entry compare and oldest detection
  for (genvar g = 0; g < ENTRIES; g++) begin : g_entry
    assign hit_vec[g]    = vld_q[g] && (la_q[g] == probe_la);
    assign oldest_vec[g] = vld_q[g] && (age_q[g] == SLOT_W'(ENTRIES - 1));
  end

  always_comb begin
    hit_slot = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (hit_vec[i]) hit_slot = SLOT_W'(i);
  end

  // Free slot first (lowest index), otherwise the least recently inserted
  always_comb begin
    logic found;
    found     = 1'b0;
    repl_slot = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (!vld_q[i] && !found) begin
        repl_slot = SLOT_W'(i);
        found     = 1'b1;
      end
    if (!found)
      for (int i = 0; i < ENTRIES; i++)
        if (oldest_vec[i]) repl_slot = SLOT_W'(i);
  end

  assign hit        = |hit_vec;
  assign hit_dirty  = drt_q[hit_slot];
  assign hit_line   = line_q[hit_slot];
  assign repl_valid = vld_q[repl_slot];
  assign repl_dirty = drt_q[repl_slot];
  assign repl_la    = la_q[repl_slot];
  assign repl_line  = line_q[repl_slot];

  // Ages form a permutation of 0..count-1 over valid entries; 0 = newest
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= '0;
      drt_q <= '0;
      for (int i = 0; i < ENTRIES; i++) age_q[i] <= '0;
    end else if (upd_en) begin
      for (int j = 0; j < ENTRIES; j++) begin
        if (SLOT_W'(j) != upd_slot && vld_q[j]) begin
          if (upd_valid) begin
            if (!vld_q[upd_slot] || age_q[j] < age_q[upd_slot])
              age_q[j] <= age_q[j] + 1'b1;
          end else if (vld_q[upd_slot] && age_q[j] > age_q[upd_slot]) begin
            age_q[j] <= age_q[j] - 1'b1;
          end
        end
      end
      age_q[upd_slot] <= '0;
      vld_q[upd_slot] <= upd_valid;
      drt_q[upd_slot] <= upd_valid & upd_dirty;
    end
  end

  always_ff @(posedge clk) begin
    if (upd_en && upd_valid) begin
      la_q[upd_slot]   <= upd_la;
      line_q[upd_slot] <= upd_line;
    end
  end

  AST_VB_UNIQUE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec)); // R7

  AST_VB_SINGLE_OLDEST: assert property (@(posedge clk) disable iff (!rst_n)
    (&vld_q) |-> ($countones(oldest_vec) == 1)); // R8

endmodule

// File: rtl/vcache_top.sv
module vcache_top #(
  parameter int ADDR_W     = 12,
  parameter int DATA_W     = 32,
  parameter int WORDS      = 4,
  parameter int SETS       = 16,
  parameter int VB_ENTRIES = 8,
  localparam int OFF_W     = $clog2(WORDS),
  localparam int LA_W      = ADDR_W - OFF_W,
  localparam int LINE_W    = WORDS * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              resp_valid,
  output logic [DATA_W-1:0] resp_rdata,
  output logic              mem_req_valid,
  output logic              mem_req_we,
  output logic [LA_W-1:0]   mem_req_line,
  output logic [LINE_W-1:0] mem_req_wdata,
  input  logic              mem_resp_valid,
  input  logic [LINE_W-1:0] mem_resp_rdata
);
  import vcache_pkg::*;

  localparam int IDX_W  = $clog2(SETS);
  localparam int TAG_W  = LA_W - IDX_W;
  localparam int SLOT_W = (VB_ENTRIES > 1) ? $clog2(VB_ENTRIES) : 1;

  function automatic logic [DATA_W-1:0] word_get(input logic [LINE_W-1:0] ln,
                                                 input logic [OFF_W-1:0] off);
    return ln[off*DATA_W +: DATA_W];
  endfunction

  function automatic logic [LINE_W-1:0] word_put(input logic [LINE_W-1:0] ln,
                                                 input logic [OFF_W-1:0] off,
                                                 input logic [DATA_W-1:0] w);
    logic [LINE_W-1:0] r;
    r = ln;
    r[off*DATA_W +: DATA_W] = w;
    return r;
  endfunction

  vc_state_e         state_q, state_d;
  logic              r_we;
  logic [ADDR_W-1:0] r_addr;
  logic [DATA_W-1:0] r_wdata;
  logic              wb_done_q;

  // Address currently being serviced
  logic [ADDR_W-1:0] cur_addr;
  logic [LA_W-1:0]   cur_la;
  logic [OFF_W-1:0]  cur_off;
  logic [IDX_W-1:0]  cur_idx;
  logic [TAG_W-1:0]  cur_tag;

  assign cur_addr = (state_q == ST_IDLE) ? req_addr : r_addr;
  assign cur_la   = cur_addr[ADDR_W-1:OFF_W];
  assign cur_off  = cur_addr[OFF_W-1:0];
  assign cur_idx  = cur_la[IDX_W-1:0];
  assign cur_tag  = cur_la[LA_W-1:IDX_W];

  // Main store
  logic              m_valid, m_dirty;
  logic [TAG_W-1:0]  m_tag;
  logic [LINE_W-1:0] m_line;
  logic              mw_en, mw_dirty;
  logic [LINE_W-1:0] mw_line;

  vc_main_array #(.SETS(SETS), .TAG_W(TAG_W), .LINE_W(LINE_W)) main_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_idx   (cur_idx),
    .rd_valid (m_valid),
    .rd_dirty (m_dirty),
    .rd_tag   (m_tag),
    .rd_line  (m_line),
    .wr_en    (mw_en),
    .wr_idx   (cur_idx),
    .wr_dirty (mw_dirty),
    .wr_tag   (cur_tag),
    .wr_line  (mw_line)
  );

  // Victim buffer
  logic              v_hit, v_hit_dirty;
  logic [SLOT_W-1:0] v_hit_slot;
  logic [LINE_W-1:0] v_hit_line;
  logic [SLOT_W-1:0] repl_slot;
  logic              repl_valid, repl_dirty;
  logic [LA_W-1:0]   repl_la;
  logic [LINE_W-1:0] repl_line;
  logic              vu_en, vu_valid;
  logic [SLOT_W-1:0] vu_slot;
  logic [LA_W-1:0]   m_la;

  assign m_la = {m_tag, cur_idx};

  vc_victim_buf #(.ENTRIES(VB_ENTRIES), .LA_W(LA_W), .LINE_W(LINE_W)) vbuf_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .probe_la   (cur_la),
    .hit        (v_hit),
    .hit_slot   (v_hit_slot),
    .hit_dirty  (v_hit_dirty),
    .hit_line   (v_hit_line),
    .repl_slot  (repl_slot),
    .repl_valid (repl_valid),
    .repl_dirty (repl_dirty),
    .repl_la    (repl_la),
    .repl_line  (repl_line),
    .upd_en     (vu_en),
    .upd_slot   (vu_slot),
    .upd_valid  (vu_valid),
    .upd_dirty  (m_dirty),
    .upd_la     (m_la),
    .upd_line   (m_line)
  );

  // Named events
  logic accept, ev_main_hit, ev_vb_hit, ev_need_wb, ev_vb_insert;
  logic fire;
  logic [DATA_W-1:0] fire_word;

  assign req_ready    = (state_q == ST_IDLE);
  assign accept       = req_valid && req_ready;
  assign ev_main_hit  = m_valid && (m_tag == cur_tag);
  assign ev_vb_hit    = v_hit;
  assign ev_need_wb   = m_valid && repl_valid && repl_dirty;
  assign ev_vb_insert = vu_en && vu_valid;

  always_comb begin
    state_d   = state_q;
    mw_en     = 1'b0;
    mw_dirty  = 1'b0;
    mw_line   = m_line;
    vu_en     = 1'b0;
    vu_valid  = 1'b0;
    vu_slot   = v_hit_slot;
    fire      = 1'b0;
    fire_word = '0;
    case (state_q)
      ST_IDLE: if (accept) begin
        if (ev_main_hit) begin
          fire      = 1'b1;
          fire_word = req_we ? req_wdata : word_get(m_line, cur_off);
          if (req_we) begin
            mw_en    = 1'b1;
            mw_dirty = 1'b1;
            mw_line  = word_put(m_line, cur_off, req_wdata);
          end
        end else if (ev_vb_hit) begin
          state_d = ST_SWAP_A;
        end else if (ev_need_wb) begin
          state_d = ST_EVICT_WR;
        end else begin
          state_d = ST_FETCH_RQ;
        end
      end
      ST_SWAP_A: state_d = ST_SWAP_B;
      ST_SWAP_B: begin
        fire      = 1'b1;
        fire_word = r_we ? r_wdata : word_get(v_hit_line, cur_off);
        mw_en     = 1'b1;
        mw_dirty  = v_hit_dirty | r_we;
        mw_line   = r_we ? word_put(v_hit_line, cur_off, r_wdata) : v_hit_line;
        vu_en     = 1'b1;
        vu_slot   = v_hit_slot;
        vu_valid  = m_valid;
        state_d   = ST_IDLE;
      end
      ST_EVICT_WR: state_d = ST_FETCH_RQ;
      ST_FETCH_RQ: state_d = ST_FETCH_WT;
      ST_FETCH_WT: if (mem_resp_valid) begin
        fire      = 1'b1;
        fire_word = r_we ? r_wdata : word_get(mem_resp_rdata, cur_off);
        mw_en     = 1'b1;
        mw_dirty  = r_we;
        mw_line   = r_we ? word_put(mem_resp_rdata, cur_off, r_wdata) : mem_resp_rdata;
        vu_en     = m_valid;
        vu_slot   = repl_slot;
        vu_valid  = 1'b1;
        state_d   = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign mem_req_valid = (state_q == ST_EVICT_WR) || (state_q == ST_FETCH_RQ);
  assign mem_req_we    = (state_q == ST_EVICT_WR);
  assign mem_req_line  = (state_q == ST_EVICT_WR) ? repl_la : cur_la;
  assign mem_req_wdata = (state_q == ST_EVICT_WR) ? repl_line : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      resp_valid <= 1'b0;
      resp_rdata <= '0;
      wb_done_q  <= 1'b0;
      r_we       <= 1'b0;
      r_addr     <= '0;
      r_wdata    <= '0;
    end else begin
      state_q    <= state_d;
      resp_valid <= fire;
      if (fire) resp_rdata <= fire_word;
      if (accept) begin
        r_we    <= req_we;
        r_addr  <= req_addr;
        r_wdata <= req_wdata;
      end
      if (state_q == ST_EVICT_WR) wb_done_q <= 1'b1;
      else if (state_q == ST_IDLE) wb_done_q <= 1'b0;
    end
  end

  AST_HIT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && ev_main_hit) |=> resp_valid); // R2

  AST_PROBE_BEFORE_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_we) |-> !ev_vb_hit); // R5

  AST_SWAP_PENALTY: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !ev_main_hit && ev_vb_hit) |=> !resp_valid ##1 !resp_valid ##1 resp_valid); // R6

  AST_INSERT_ONLY_EVICTED: assert property (@(posedge clk) disable iff (!rst_n)
    ev_vb_insert |-> (m_valid && (m_tag != cur_tag) &&
                      (state_q == ST_SWAP_B || state_q == ST_FETCH_WT))); // R7

  AST_WB_BEFORE_REUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_FETCH_WT && mem_resp_valid && m_valid && repl_valid && repl_dirty)
      |-> wb_done_q); // R9

  AST_RESP_ONLY_WAITING: assert property (@(posedge clk) disable iff (!rst_n)
    mem_resp_valid |-> (state_q == ST_FETCH_WT)); // R4

endmodule

// File: tb/vcache_top_tb_top.sv
module vcache_top_tb_top;

  localparam int ADDR_W = 12;
  localparam int DATA_W = 32;
  localparam int LA_W   = ADDR_W - 2;
  localparam int LINE_W = 4 * DATA_W;
  localparam int NLINES = 1 << LA_W;
  localparam int MEM_LAT = 3;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req_valid = 1'b0;
  logic              req_ready;
  logic              req_we = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [DATA_W-1:0] req_wdata = '0;
  logic              resp_valid;
  logic [DATA_W-1:0] resp_rdata;
  logic              mem_req_valid;
  logic              mem_req_we;
  logic [LA_W-1:0]   mem_req_line;
  logic [LINE_W-1:0] mem_req_wdata;
  logic              mem_resp_valid;
  logic [LINE_W-1:0] mem_resp_rdata;

  always #4 clk = ~clk;

  vcache_top dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_we(req_we),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .resp_valid(resp_valid), .resp_rdata(resp_rdata),
    .mem_req_valid(mem_req_valid), .mem_req_we(mem_req_we),
    .mem_req_line(mem_req_line), .mem_req_wdata(mem_req_wdata),
    .mem_resp_valid(mem_resp_valid), .mem_resp_rdata(mem_resp_rdata)
  );

  function automatic logic [DATA_W-1:0] init_word(input int la, input int w);
    return 32'hA500_0000 | DATA_W'(la << 4) | DATA_W'(w);
  endfunction

  function automatic logic [LINE_W-1:0] init_line(input int la);
    logic [LINE_W-1:0] r;
    for (int w = 0; w < 4; w++) r[w*DATA_W +: DATA_W] = init_word(la, w);
    return r;
  endfunction

  // Lower-level memory model
  logic [LINE_W-1:0] mem [NLINES];
  logic [NLINES-1:0] written;
  logic              pend;
  logic [LA_W-1:0]   pend_la;
  int                pend_cnt;
  int                tick, rd_cnt, wr_cnt, rd_tick, wr_tick;
  logic [LA_W-1:0]   last_rd_la, last_wr_la;
  logic [LINE_W-1:0] last_wr_data;

  always @(posedge clk) begin
    tick <= tick + 1;
    mem_resp_valid <= 1'b0;
    if (!rst_n) begin
      tick <= 0; pend <= 1'b0; written <= '0;
      rd_cnt <= 0; wr_cnt <= 0; rd_tick <= 0; wr_tick <= 0;
      pend_la <= '0; pend_cnt <= 0; last_rd_la <= '0; last_wr_la <= '0;
      last_wr_data <= '0; mem_resp_rdata <= '0;
    end else begin
      if (mem_req_valid) begin
        if (mem_req_we) begin
          mem[mem_req_line] <= mem_req_wdata;
          written[mem_req_line] <= 1'b1;
          wr_cnt <= wr_cnt + 1; wr_tick <= tick;
          last_wr_la <= mem_req_line; last_wr_data <= mem_req_wdata;
        end else begin
          pend <= 1'b1; pend_la <= mem_req_line; pend_cnt <= MEM_LAT;
          rd_cnt <= rd_cnt + 1; rd_tick <= tick; last_rd_la <= mem_req_line;
        end
      end
      if (pend) begin
        if (pend_cnt == 1) begin
          pend <= 1'b0;
          mem_resp_valid <= 1'b1;
          mem_resp_rdata <= written[pend_la] ? mem[pend_la] : init_line(int'(pend_la));
        end else begin
          pend_cnt <= pend_cnt - 1;
        end
      end
    end
  end

  // Expected word contents
  logic [DATA_W-1:0] shadow [1 << ADDR_W];
  int n_chk = 0;
  int n_bad = 0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic access(input logic we, input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d,
                        output logic [DATA_W-1:0] rd, output int lat);
    @(negedge clk);
    req_valid = 1'b1; req_we = we; req_addr = a; req_wdata = d;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    lat = 1;
    while (!resp_valid && lat < 200) begin
      @(negedge clk);
      lat++;
    end
    rd = resp_rdata;
    if (we) shadow[a] = d;
  endtask

  localparam logic [ADDR_W-1:0] A_ADDR = 12'h010;
  localparam logic [ADDR_W-1:0] B_ADDR = 12'h050;
  localparam logic [DATA_W-1:0] ST_VAL = 32'hDEAD_0011;

  task automatic t_reset();
    @(negedge clk);
    chk("R1 req_ready", 64'(req_ready), 64'd1);
    chk("R1 resp_valid", 64'(resp_valid), 64'd0);
    chk("R1 mem_req_valid", 64'(mem_req_valid), 64'd0);
  endtask

  task automatic t_cold_miss();
    logic [DATA_W-1:0] rd; int lat; int r0;
    r0 = rd_cnt;
    access(1'b0, A_ADDR, '0, rd, lat);
    chk("R1 first access misses", 64'(lat > 3), 64'd1);
    chk("R4 one read", 64'(rd_cnt - r0), 64'd1);
    chk("R3 read line address", 64'(last_rd_la), 64'(A_ADDR >> 2));
    chk("R4 miss data", 64'(rd), 64'(shadow[A_ADDR]));
  endtask

  task automatic t_hits();
    logic [DATA_W-1:0] rd; int lat; int r0; int w0;
    r0 = rd_cnt; w0 = wr_cnt;
    access(1'b0, A_ADDR + 2, '0, rd, lat);
    chk("R2 load hit latency", 64'(lat), 64'd1);
    chk("R2 load hit data", 64'(rd), 64'(shadow[A_ADDR + 2]));
    access(1'b1, A_ADDR + 1, ST_VAL, rd, lat);
    chk("R2 store hit latency", 64'(lat), 64'd1);
    chk("R2 store echo", 64'(rd), 64'(ST_VAL));
    access(1'b0, A_ADDR + 1, '0, rd, lat);
    chk("R2 stored word read", 64'(rd), 64'(ST_VAL));
    chk("R2 no traffic", 64'((rd_cnt - r0) + (wr_cnt - w0)), 64'd0);
  endtask

  task automatic t_conflict_swap();
    logic [DATA_W-1:0] rd; int lat; int r0; int w0;
    r0 = rd_cnt;
    access(1'b0, B_ADDR + 3, '0, rd, lat);
    chk("R3 same index conflicts", 64'(rd_cnt - r0), 64'd1);
    chk("R3 conflict line address", 64'(last_rd_la), 64'(B_ADDR >> 2));
    chk("R4 conflict data", 64'(rd), 64'(shadow[B_ADDR + 3]));
    r0 = rd_cnt; w0 = wr_cnt;
    access(1'b0, A_ADDR + 1, '0, rd, lat);
    chk("R6 victim hit latency", 64'(lat), 64'd3);
    chk("R9 dirty word kept in buffer", 64'(rd), 64'(ST_VAL));
    access(1'b0, B_ADDR, '0, rd, lat);
    chk("R6 swapped-out line found", 64'(lat), 64'd3);
    chk("R6 swapped-out data", 64'(rd), 64'(shadow[B_ADDR]));
    chk("R5 no memory on victim hits", 64'((rd_cnt - r0) + (wr_cnt - w0)), 64'd0);
  endtask

  task automatic t_fifo_and_writeback();
    logic [DATA_W-1:0] rd; int lat; int r0; int w0;
    logic [ADDR_W-1:0] ca;
    w0 = wr_cnt;
    for (int k = 2; k <= 8; k++) begin
      ca = A_ADDR + ADDR_W'(64 * k);
      access(1'b0, ca, '0, rd, lat);
      chk("R4 conflict fill data", 64'(rd), 64'(shadow[ca]));
    end
    chk("R10 no write while buffer fills", 64'(wr_cnt - w0), 64'd0);
    ca = A_ADDR + ADDR_W'(64 * 9);
    access(1'b0, ca, '0, rd, lat);
    chk("R9 dirty oldest written back", 64'(wr_cnt - w0), 64'd1);
    chk("R8 oldest pushed out", 64'(last_wr_la), 64'(A_ADDR >> 2));
    chk("R9 write-back data", 64'(last_wr_data[DATA_W +: DATA_W]), 64'(ST_VAL));
    chk("R9 write before read", 64'(wr_tick < rd_tick), 64'd1);
    r0 = rd_cnt; w0 = wr_cnt;
    access(1'b0, B_ADDR + 1, '0, rd, lat);
    chk("R7 refills took no slot", 64'(lat), 64'd3);
    chk("R8 second oldest kept", 64'(rd_cnt - r0), 64'd0);
    access(1'b0, A_ADDR + 1, '0, rd, lat);
    chk("R8 pushed-out line refetched", 64'(rd_cnt - r0), 64'd1);
    chk("R10 clean push-out not written", 64'(wr_cnt - w0), 64'd0);
    chk("R9 written-back data returns", 64'(rd), 64'(ST_VAL));
  endtask

  task automatic t_store_miss();
    logic [DATA_W-1:0] rd; int lat; int r0;
    r0 = rd_cnt;
    access(1'b1, 12'h302, 32'h1234_5678, rd, lat);
    chk("R4 store miss reads line", 64'(rd_cnt - r0), 64'd1);
    access(1'b0, 12'h302, '0, rd, lat);
    chk("R4 merged store hits", 64'(lat), 64'd1);
    chk("R4 merged store data", 64'(rd), 64'h1234_5678);
    access(1'b0, 12'h303, '0, rd, lat);
    chk("R4 neighbour word kept", 64'(rd), 64'(shadow[12'h303]));
  endtask

  initial begin
    for (int a = 0; a < (1 << ADDR_W); a++) shadow[a] = init_word(a >> 2, a & 3);
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_cold_miss();
    t_hits();
    t_conflict_swap();
    t_fifo_and_writeback();
    t_store_miss();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule